// File: doc/BRIEF.md
# Multi-Channel DAC Code Trim Engine

This block applies a digital gain and offset correction to the codes of a 16-channel, 12-bit voltage DAC. Each channel keeps three settings: a raw code, a gain trim and an offset trim. From these it derives a corrected code:

code = floor(raw × (gain + 2) / 4096) + offset − 2048

The result is clamped to the 12-bit range. The reset trims give a gain of exactly one and an offset of zero, so an untrimmed channel passes its raw code through unchanged.

Corrected codes first land in a per-channel pending buffer. A single shared load pulse copies all sixteen pending codes into the output registers on the same clock edge, so every output changes together.

Settings arrive on a valid/ready write stream. A beat is taken on a rising clock edge where both `wr_valid` and `wr_ready` are high. The block applies back-pressure only during and directly after reset: `wr_ready` is low while `rst` is high and rises on the first edge after `rst` falls. A source that holds `wr_valid` with stable fields while `wr_ready` is low loses nothing. Once out of reset the port takes one beat per clock without stalling.

Top module: `calib_engine`

## Requirements
- R1: A synchronous reset clears every output code and pending code to 0. It sets every raw code to 0, every gain trim to 0xFFE and every offset trim to 0x800. As a result, a raw code written after reset and then loaded appears unchanged at the output.
- R2: The corrected code is floor(raw × (gain + 2) / 4096) + offset − 2048. The product is kept at full precision and truncated by the shift before the offset is added.
- R3: Bit 0 of a stored gain trim is always 0, whatever value is written.
- R4: A corrected value below 0 is stored as 0.
- R5: A corrected value above 4095 is stored as 4095.
- R6: Every channel has its own raw, gain and offset settings. A write to one channel leaves the codes of all other channels unchanged.
- R7: Output codes change only on an edge where `load` is high. On that edge every channel takes its pending code.
- R8: A write taken on edge E updates that channel's pending code by edge E+1. A load sampled on edge E+2 therefore delivers the new code.
- R9: `wr_sel` encodes 0 = raw code, 1 = gain trim, 2 = offset trim. A beat with `wr_sel` = 3 changes none of the channel's settings.
- R10: When a write and a load are taken on the same edge, the load transfers the pending code as it stood before that write.
- R11: `wr_ready` is low during reset and high from the first edge after reset. Beats offered while `wr_ready` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat can be taken |
| wr_ch | input | 4 | Target channel |
| wr_sel | input | 2 | Setting select: 0 raw, 1 gain, 2 offset, 3 none |
| wr_data | input | 12 | Setting value |
| load | input | 1 | Copy all pending codes to the outputs |
| dac_codes | output | 192 | Output codes; channel k in bits [12k+11:12k] |

## Verification
Untrimmed channels are driven with raw codes to show unity pass-through. A mid-range gain trim combined with a shifted offset exposes the truncation point and the order in which the terms are added. An odd gain value separates a design that keeps the gain LSB from one that clears it. Small raw codes with a zero offset, and large raw codes with a full-scale offset, drive the clamp from each side. Loads are placed one and two edges after a write, and on the same edge as a write, to separate the pending stage from the output stage. A behavioural model predicts every output code on every cycle, which shows up any change to a channel that was not written.

// File: rtl/calib_pkg.sv
package calib_pkg;
  parameter int NUM_CH  = 16;
  parameter int CODE_WD = 12;

  typedef enum logic [1:0] {
    SEL_RAW  = 2'd0,
    SEL_GAIN = 2'd1,
    SEL_OFS  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/calib_regbank.sv
module calib_regbank
  import calib_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int CODE_W = CODE_WD,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CH_W-1:0]   wr_ch,
  input  sel_e              wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  output logic              calc_vld,
  output logic [CH_W-1:0]   calc_ch,
  output logic [CODE_W-1:0] cur_raw,
  output logic [CODE_W-1:0] cur_gain,
  output logic [CODE_W-1:0] cur_ofs
);
  localparam logic [CODE_W-1:0] GAIN_RST = {{(CODE_W-1){1'b1}}, 1'b0};
  localparam logic [CODE_W-1:0] OFS_RST  = {1'b1, {(CODE_W-1){1'b0}}};

  logic [N_CH*CODE_W-1:0] raw_all, gain_all, ofs_all;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [CH_W-1:0] IDX = CH_W'(g);
    logic [CODE_W-1:0] raw_r, gain_r, ofs_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        raw_r  <= '0;
        gain_r <= GAIN_RST;
        ofs_r  <= OFS_RST;
      end else if (we && wr_ch == IDX) begin
        case (wr_sel)
          SEL_RAW:  raw_r  <= wr_data;
          SEL_GAIN: gain_r <= {wr_data[CODE_W-1:1], 1'b0};
          SEL_OFS:  ofs_r  <= wr_data;
          default:  ;
        endcase
      end
    end

    assign raw_all[g*CODE_W +: CODE_W]  = raw_r;
    assign gain_all[g*CODE_W +: CODE_W] = gain_r;
    assign ofs_all[g*CODE_W +: CODE_W]  = ofs_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      calc_vld <= 1'b0;
      calc_ch  <= '0;
    end else begin
      calc_vld <= we && (wr_sel != SEL_NONE);
      calc_ch  <= wr_ch;
    end
  end

  assign cur_raw  = raw_all[calc_ch*CODE_W +: CODE_W];
  assign cur_gain = gain_all[calc_ch*CODE_W +: CODE_W];
  assign cur_ofs  = ofs_all[calc_ch*CODE_W +: CODE_W];
endmodule

// File: rtl/calib_math.sv
module calib_math #(
  parameter int CODE_W = 12,
  localparam int PW    = 2*CODE_W + 1,
  localparam int SW    = PW + 1
) (
  input  logic [CODE_W-1:0] raw,
  input  logic [CODE_W-1:0] gain,
  input  logic [CODE_W-1:0] ofs,
  output logic [CODE_W-1:0] code
);
  localparam logic [SW-1:0] HALF = SW'(1) << (CODE_W-1);

  logic [CODE_W:0] gain_p2;
  logic [PW-1:0]   prod;
  logic [SW-1:0]   sum;
  logic            neg, over;

  always_comb begin
    gain_p2 = {1'b0, gain} + (CODE_W+1)'(2);
    prod    = PW'(raw) * PW'(gain_p2);
    sum     = {1'b0, prod >> CODE_W} + SW'(ofs) - HALF;
    neg     = sum[SW-1];
    over    = |sum[SW-2:CODE_W];
    if (neg)       code = '0;
    else if (over) code = '1;
    else           code = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/calib_dbuf.sv
module calib_dbuf #(
  parameter int N_CH   = 16,
  parameter int CODE_W = 12,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   upd,
  input  logic [CH_W-1:0]        upd_ch,
  input  logic [CODE_W-1:0]      upd_code,
  input  logic                   load,
  output logic [N_CH*CODE_W-1:0] pend_codes,
  output logic [N_CH*CODE_W-1:0] dac_codes
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [CH_W-1:0] IDX = CH_W'(g);
    logic [CODE_W-1:0] pend_r, dac_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_r <= '0;
        dac_r  <= '0;
      end else begin
        if (upd && upd_ch == IDX) pend_r <= upd_code;
        if (load)                 dac_r  <= pend_r;
      end
    end

    assign pend_codes[g*CODE_W +: CODE_W] = pend_r;
    assign dac_codes[g*CODE_W +: CODE_W]  = dac_r;
  end
endmodule

// File: rtl/calib_engine.sv
module calib_engine
  import calib_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int CODE_W = CODE_WD,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [CH_W-1:0]        wr_ch,
  input  logic [1:0]             wr_sel,
  input  logic [CODE_W-1:0]      wr_data,
  input  logic                   load,
  output logic [N_CH*CODE_W-1:0] dac_codes
);
  logic                   rdy_q;
  logic                   fire;
  logic                   calc_vld;
  logic [CH_W-1:0]        calc_ch;
  logic [CODE_W-1:0]      cur_raw, cur_gain, cur_ofs, calc_code;
  logic [N_CH*CODE_W-1:0] pend_codes;

  always_ff @(posedge clk) begin
    rdy_q <= ~rst;
  end

  assign wr_ready = rdy_q;
  assign fire     = wr_valid & rdy_q;

  calib_regbank #(.N_CH(N_CH), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .we(fire), .wr_ch(wr_ch), .wr_sel(sel_e'(wr_sel)),
    .wr_data(wr_data), .calc_vld(calc_vld), .calc_ch(calc_ch),
    .cur_raw(cur_raw), .cur_gain(cur_gain), .cur_ofs(cur_ofs)
  );

  calib_math #(.CODE_W(CODE_W)) u_math (
    .raw(cur_raw), .gain(cur_gain), .ofs(cur_ofs), .code(calc_code)
  );

  calib_dbuf #(.N_CH(N_CH), .CODE_W(CODE_W)) u_dbuf (
    .clk(clk), .rst(rst), .upd(calc_vld), .upd_ch(calc_ch),
    .upd_code(calc_code), .load(load), .pend_codes(pend_codes),
    .dac_codes(dac_codes)
  );
endmodule

// File: rtl/calib_engine_chk.sv
module calib_engine_chk #(
  parameter int N_CH   = 16,
  parameter int CODE_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [1:0]             wr_sel,
  input logic                   load,
  input logic                   calc_vld,
  input logic [N_CH*CODE_W-1:0] pend,
  input logic [N_CH*CODE_W-1:0] dac
);
  // R1: outputs are zero right after a reset cycle
  p_reset_zero_r1: assert property (@(posedge clk) $past(rst) |-> dac == '0);

  // R7: outputs hold without a load
  p_hold_no_load_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dac));

  // R7: a load copies every pending code at once
  p_load_copy_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> dac == $past(pend));

  // R8: a taken settings write starts a recalculation on the next cycle
  p_recalc_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && wr_sel != 2'd3) |=> calc_vld);

  // R9: an unused select starts no recalculation
  p_sel_none_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && wr_sel == 2'd3) |=> !calc_vld);

  // R11: no back-pressure release during reset
  p_ready_reset_r11: assert property (@(posedge clk)
    rst |=> !wr_ready);
endmodule

bind calib_engine calib_engine_chk #(.N_CH(N_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_sel(wr_sel), .load(load), .calc_vld(calc_vld), .pend(pend_codes),
  .dac(dac_codes)
);

// File: tb/calib_engine_test.sv
`timescale 1ns/1ps
module calib_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_ch = '0;
  logic [1:0]  wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic        load = 1'b0;
  logic [191:0] dac_codes;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  calib_engine uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data), .load(load),
    .dac_codes(dac_codes)
  );

  // behavioural reference model
  int m_raw[16], m_gain[16], m_ofs[16], m_pend[16], m_dac[16];
  int calc_q[$];
  bit m_rdy = 0;

  function automatic int ref_code(int raw, int gain, int ofs);
    int v;
    v = (raw * (gain + 2)) / 4096 + ofs - 2048;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin
        m_raw[i] = 0; m_gain[i] = 12'hFFE; m_ofs[i] = 12'h800;
        m_pend[i] = 0; m_dac[i] = 0;
      end
      calc_q.delete();
    end else begin
      if (load) for (int i = 0; i < 16; i++) m_dac[i] = m_pend[i];
      if (calc_q.size() > 0) begin
        int ch;
        ch = calc_q.pop_front();
        m_pend[ch] = ref_code(m_raw[ch], m_gain[ch], m_ofs[ch]);
      end
      if (wr_valid && m_rdy && wr_sel != 2'd3) begin
        case (wr_sel)
          2'd0: m_raw[wr_ch] = int'(wr_data);
          2'd1: m_gain[wr_ch] = int'(wr_data) & 12'hFFE;
          default: m_ofs[wr_ch] = int'(wr_data);
        endcase
        calc_q.push_back(int'(wr_ch));
      end
    end
    m_rdy = !rst;
  end

  // compare every cycle (R6, R7 cycle accuracy)
  always @(negedge clk) begin
    if (!done) begin
      bit bad;
      bad = 0;
      checks++;
      for (int i = 0; i < 16; i++)
        if (int'(dac_codes[i*12 +: 12]) != m_dac[i]) begin
          bad = 1;
          $display("FAIL R6/R7 model ch%0d actual=%0d expected=%0d", i,
                   dac_codes[i*12 +: 12], m_dac[i]);
        end
      if (wr_ready !== m_rdy) begin
        bad = 1;
        $display("FAIL R11 model ready actual=%0b expected=%0b", wr_ready, m_rdy);
      end
      if (bad) errors++;
    end
  end

  task automatic check_code(string tag, int ch, int exp);
    checks++;
    if (int'(dac_codes[ch*12 +: 12]) != exp) begin
      errors++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d", tag, ch,
               dac_codes[ch*12 +: 12], exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // drive at a negedge; return at the negedge after the taking edge
  task automatic wr(int ch, int sel, int data);
    wr_valid = 1; wr_ch = 4'(ch); wr_sel = 2'(sel); wr_data = 12'(data);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic pulse_load();
    load = 1;
    @(negedge clk);
    load = 0;
  endtask

  initial begin
    #(20000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_bit("R11 ready low in reset", wr_ready, 1'b0);
    rst = 0;
    @(negedge clk);
    check_bit("R11 ready after reset", wr_ready, 1'b1);
    for (int i = 0; i < 16; i++) check_code("R1 reset code", i, 0);

    // R1/R2: unity pass-through with reset trims
    wr(5, 0, 1234); idle(); pulse_load();
    check_code("R1 unity", 5, 1234);

    // R2: gain 0x800, default offset -> 1501; then offset 0x900 -> 1757
    wr(0, 0, 3000); wr(0, 1, 12'h800); idle(); pulse_load();
    check_code("R2 gain", 0, 1501);
    wr(0, 2, 12'h900); idle(); pulse_load();
    check_code("R2 offset", 0, 1757);

    // R3: odd gain stored even -> still 1757 (1758 if LSB kept)
    wr(0, 1, 12'h801); idle(); pulse_load();
    check_code("R3 gain lsb", 0, 1757);

    // R4 / R5 clamps
    wr(1, 0, 100); wr(1, 2, 0); idle(); pulse_load();
    check_code("R4 underflow", 1, 0);
    wr(2, 0, 4000); wr(2, 2, 12'hFFF); idle(); pulse_load();
    check_code("R5 overflow", 2, 4095);

    // R6: untouched channels keep values
    check_code("R6 untouched ch3", 3, 0);
    check_code("R6 untouched ch5", 5, 1234);

    // R7: no change without load
    wr(5, 0, 99); idle(); idle(); idle();
    check_code("R7 hold", 5, 1234);
    pulse_load();
    check_code("R7 after load", 5, 99);

    // R8: load one edge after write gives old, two edges after gives new
    wr(4, 0, 321); pulse_load();
    check_code("R8 too early", 4, 0);
    pulse_load();
    check_code("R8 latency", 4, 321);

    // R9: select 3 changes nothing
    wr(5, 3, 12'h123); idle(); pulse_load();
    check_code("R9 sel none", 5, 99);
    wr(5, 0, 4000); idle(); pulse_load();
    check_code("R9 trims intact", 5, 4000);

    // R10: write and load on the same edge
    wr(6, 0, 500); idle(); pulse_load();
    check_code("R10 setup", 6, 500);
    wr_valid = 1; wr_ch = 4'd6; wr_sel = 2'd0; wr_data = 12'd700; load = 1;
    @(negedge clk);
    wr_valid = 0; load = 0;
    check_code("R10 same edge", 6, 500);
    idle(); pulse_load();
    check_code("R10 next load", 6, 700);

    // R11: beats offered during reset are dropped
    rst = 1;
    wr_valid = 1; wr_ch = 4'd7; wr_sel = 2'd0; wr_data = 12'd222;
    @(negedge clk);
    check_bit("R11 ready in reset", wr_ready, 1'b0);
    rst = 0;
    wr_valid = 0;
    check_code("R1 re-reset", 6, 0);
    idle(); pulse_load();
    check_code("R11 dropped beat", 7, 0);
    wr(7, 0, 222); idle(); pulse_load();
    check_code("R1 unity after reset", 7, 222);

    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule